// File: doc/BRIEF.md
# Thirty-Two Pin I/O Port with Event Interrupts

This block is a 32-pin general-purpose input/output port behind a simple register bus. Software drives pins through a data register and a per-pin direction register. It can also update the data register atomically through write-only set, clear and toggle aliases. The pin levels come back through a two-flop synchroniser and can be read as a pad status word.

Every pin also feeds an event detector. The detector follows a 2-bit sense mode per pin. An edge-select bit per pin can override that mode so that any transition counts. A detected event latches a sticky status bit. Masked status is then combined into two half-port interrupt lines, and pins 0 to 7 each also get a dedicated line.

The bus has no wait states. A write takes effect at the clock edge where `busWe` is high. Read data is combinational from `busAddr` and the current register state.

Top module: `gpio_irq_port`

## Requirements
- R1: An active-low asynchronous reset clears the data, direction, both configuration, mask, status and edge-select registers, and the synchroniser and previous-level flops.
- R2: `padOe` equals the direction register and `padOut` equals the data register. A pin with direction bit 1 is driven; a pin with direction bit 0 is an input.
- R3: The pad status word, read at byte offset 0x08, returns `padIn` delayed by exactly two clocks.
- R4: A write to 0x84 ORs the written word into the data register. A write to 0x88 clears the data bits written as 1. A write to 0x8C inverts the data bits written as 1. Bits written as 0 leave the data register unchanged.
- R5: Pin n takes its sense mode from bits [2m+1:2m], where m = n mod 16. That field lives in the register at 0x0C for pins 0–15 and in the register at 0x10 for pins 16–31.
- R6: In sense mode 00 the pin's status bit is set on every cycle that its synchronised level is 0. In mode 01 the same holds for level 1, so a level event reasserts the bit on the cycle after a clear while the level persists.
- R7: Sense mode 10 sets the status bit once per 0-to-1 change of the synchronised level. Mode 11 sets it once per 1-to-0 change.
- R8: When a pin's bit in the edge-select register (0x1C) is 1, either direction of change sets its status bit and its sense field has no effect.
- R9: An event sets the status bit (0x18) even when the pin's mask bit (0x14) is 0. Writing 1 to a status bit clears it, and writing 0 has no effect.
- R10: When a clear of a status bit and a new event for that pin fall in the same cycle, the bit ends up set.
- R11: `irqLow` is the OR over pins 0–15 of status AND mask, and `irqHigh` is the same OR over pins 16–31.
- R12: `irqPin[k]` for k in 0–7 is status bit k AND mask bit k.
- R13: Reads at 0x00, 0x04, 0x0C, 0x10, 0x14, 0x18 and 0x1C return the data, direction, configuration 1, configuration 2, mask, status and edge-select registers. Reads of the alias offsets or of any unmapped offset return 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe for the addressed register |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |
| padIn | input | 32 | Pin levels from the pads, asynchronous |
| padOut | output | 32 | Output levels to the pads |
| padOe | output | 32 | Per-pin output enable |
| irqLow | output | 1 | Combined interrupt for pins 0–15 |
| irqHigh | output | 1 | Combined interrupt for pins 16–31 |
| irqPin | output | 8 | Dedicated interrupts for pins 0–7 |

## Verification
The embedded properties assume one access per cycle and no second writer to the status word. The cleared bits of a status write are then exactly the bits written as 1, and a bit that is set and not cleared is expected to stay set. The stimulus holds `busWe` for a single cycle per access and changes `padIn` and the bus only on the falling clock edge, so the synchroniser and detector see clean values at every rising edge. A behavioural model in the bench tracks all registers and is compared against every output each cycle. The comparison runs through reset, through mixed sense modes on both half-words, and through cycles where a status clear and a persisting level collide.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_COUNT   = 32;
  localparam int HALF_PINS   = PIN_COUNT / 2;
  localparam int SENSE_W     = 2;
  localparam int CFG_W       = HALF_PINS * SENSE_W;
  localparam int ADDR_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int DIRECT_IRQS = 8;

  localparam logic [ADDR_W-1:0] OFF_DATA   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PAD    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CFGLO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CFGHI  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_EDGE   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SET    = 8'h84;
  localparam logic [ADDR_W-1:0] OFF_CLR    = 8'h88;
  localparam logic [ADDR_W-1:0] OFF_TOG    = 8'h8C;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DATA, RD_DIR, RD_PAD, RD_CFGLO,
    RD_CFGHI, RD_MASK, RD_STAT, RD_EDGE
  } rd_sel_e;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrCfgLo;
    logic    wrCfgHi;
    logic    wrMask;
    logic    wrStat;
    logic    wrEdge;
    logic    wrSet;
    logic    wrClr;
    logic    wrTog;
    rd_sel_e rdSel;
  } ctrl_strobe_t;

  function automatic logic senseHit(input logic [SENSE_W-1:0] mode,
                                    input logic lvl, input logic prv);
    case (sense_e'(mode))
      SENSE_LOW:  senseHit = ~lvl;
      SENSE_HIGH: senseHit = lvl;
      SENSE_RISE: senseHit = lvl & ~prv;
      default:    senseHit = ~lvl & prv;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrl_strobe_t      strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdSel = RD_ZERO;
    case (busAddr)
      OFF_DATA:  begin strobe.rdSel = RD_DATA;  strobe.wrData  = busWe; end
      OFF_DIR:   begin strobe.rdSel = RD_DIR;   strobe.wrDir   = busWe; end
      OFF_PAD:   strobe.rdSel = RD_PAD;
      OFF_CFGLO: begin strobe.rdSel = RD_CFGLO; strobe.wrCfgLo = busWe; end
      OFF_CFGHI: begin strobe.rdSel = RD_CFGHI; strobe.wrCfgHi = busWe; end
      OFF_MASK:  begin strobe.rdSel = RD_MASK;  strobe.wrMask  = busWe; end
      OFF_STAT:  begin strobe.rdSel = RD_STAT;  strobe.wrStat  = busWe; end
      OFF_EDGE:  begin strobe.rdSel = RD_EDGE;  strobe.wrEdge  = busWe; end
      OFF_SET:   strobe.wrSet = busWe;
      OFF_CLR:   strobe.wrClr = busWe;
      OFF_TOG:   strobe.wrTog = busWe;
      default:   ;
    endcase
  end

  // R13: one address selects at most one target register per write
  always_comb begin
    a_r13_single_target: assert ($onehot0({strobe.wrData, strobe.wrDir, strobe.wrCfgLo,
                                            strobe.wrCfgHi, strobe.wrMask, strobe.wrStat,
                                            strobe.wrEdge, strobe.wrSet, strobe.wrClr,
                                            strobe.wrTog}));
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  ctrl_strobe_t           strobe,
  input  logic [PIN_COUNT-1:0]   busWdata,
  output logic [PIN_COUNT-1:0]   busRdata,
  input  logic [PIN_COUNT-1:0]   padIn,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic                   irqLow,
  output logic                   irqHigh,
  output logic [DIRECT_IRQS-1:0] irqPin
);
  logic [PIN_COUNT-1:0] dataQ, dirQ, maskQ, statusQ, edgeQ, prevQ;
  logic [CFG_W-1:0]     cfgLoQ, cfgHiQ;
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] syncLvl, eventVec, clrVec, pendVec;

  assign syncLvl = syncQ[SYNC_STAGES-1];
  assign clrVec  = strobe.wrStat ? busWdata : '0;

  // Input synchroniser and previous-level history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncLvl;
    end
  end

  // Per-pin event detection; the sense field comes from the half-word owning the pin
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int SLOT = p % HALF_PINS;
    logic [SENSE_W-1:0] mode;
    if (p < HALF_PINS) begin : g_lo
      assign mode = cfgLoQ[SENSE_W*SLOT +: SENSE_W];
    end else begin : g_hi
      assign mode = cfgHiQ[SENSE_W*SLOT +: SENSE_W];
    end
    assign eventVec[p] = edgeQ[p] ? (syncLvl[p] ^ prevQ[p])
                                  : senseHit(mode, syncLvl[p], prevQ[p]);
  end

  // Register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ   <= '0;
      dirQ    <= '0;
      cfgLoQ  <= '0;
      cfgHiQ  <= '0;
      maskQ   <= '0;
      statusQ <= '0;
      edgeQ   <= '0;
    end else begin
      if (strobe.wrData)  dataQ  <= busWdata;
      if (strobe.wrSet)   dataQ  <= dataQ | busWdata;
      if (strobe.wrClr)   dataQ  <= dataQ & ~busWdata;
      if (strobe.wrTog)   dataQ  <= dataQ ^ busWdata;
      if (strobe.wrDir)   dirQ   <= busWdata;
      if (strobe.wrCfgLo) cfgLoQ <= busWdata[CFG_W-1:0];
      if (strobe.wrCfgHi) cfgHiQ <= busWdata[CFG_W-1:0];
      if (strobe.wrMask)  maskQ  <= busWdata;
      if (strobe.wrEdge)  edgeQ  <= busWdata;
      statusQ <= (statusQ & ~clrVec) | eventVec;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_DATA:  busRdata = dataQ;
      RD_DIR:   busRdata = dirQ;
      RD_PAD:   busRdata = syncLvl;
      RD_CFGLO: busRdata = PIN_COUNT'(cfgLoQ);
      RD_CFGHI: busRdata = PIN_COUNT'(cfgHiQ);
      RD_MASK:  busRdata = maskQ;
      RD_STAT:  busRdata = statusQ;
      RD_EDGE:  busRdata = edgeQ;
      default:  busRdata = '0;
    endcase
  end

  assign padOut  = dataQ;
  assign padOe   = dirQ;
  assign pendVec = statusQ & maskQ;
  assign irqLow  = |pendVec[HALF_PINS-1:0];
  assign irqHigh = |pendVec[PIN_COUNT-1:HALF_PINS];
  assign irqPin  = pendVec[DIRECT_IRQS-1:0];

  // R9: a status bit that is set and not cleared stays set
  a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(statusQ) & ~$past(clrVec) & ~statusQ) == '0));
  // R10: every detected event is visible in status next cycle, clear or not
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|eventVec) |=> ((statusQ & $past(eventVec)) == $past(eventVec)));
  // R4: set alias only ever raises bits
  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrSet |=> ((dataQ & $past(busWdata)) == $past(busWdata)));
  // R4: clear alias drops exactly the written ones
  a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrClr |=> (dataQ == ($past(dataQ) & ~$past(busWdata))));
  // R4: toggle alias flips exactly the written ones
  a_r4_tog_flips: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrTog |=> (dataQ == ($past(dataQ) ^ $past(busWdata))));
  // R8: an edge-selected pin with a stable level raises no event
  a_r8_edge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((eventVec & edgeQ & ~(syncLvl ^ prevQ)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busWe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [PIN_COUNT-1:0]   busWdata,
  output logic [PIN_COUNT-1:0]   busRdata,
  input  logic [PIN_COUNT-1:0]   padIn,
  output logic [PIN_COUNT-1:0]   padOut,
  output logic [PIN_COUNT-1:0]   padOe,
  output logic                   irqLow,
  output logic                   irqHigh,
  output logic [DIRECT_IRQS-1:0] irqPin
);
  ctrl_strobe_t strobe;

  gpio_irq_ctrl u_ctrl (
    .busWe   (busWe),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_irq_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh),
    .irqPin   (irqPin)
  );
endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] padIn = '0;
  logic [31:0] busRdata, padOut, padOe;
  logic        irqLow, irqHigh;
  logic [7:0]  irqPin;

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqLow(irqLow), .irqHigh(irqHigh),
    .irqPin(irqPin)
  );

  // Behavioural reference model
  bit [31:0] mData, mDir, mCfgLo, mCfgHi, mMask, mStat, mEdge;
  bit [31:0] mS1, mS2, mPrev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mData = 0; mDir = 0; mCfgLo = 0; mCfgHi = 0; mMask = 0;
      mStat = 0; mEdge = 0; mS1 = 0; mS2 = 0; mPrev = 0;
    end else begin
      bit [31:0] ev;
      ev = 0;
      for (int i = 0; i < 32; i++) begin
        int md;
        bit lv, pv;
        md = (i < 16) ? int'((mCfgLo >> (2*i)) & 3) : int'((mCfgHi >> (2*(i-16))) & 3);
        lv = mS2[i]; pv = mPrev[i];
        if (mEdge[i]) ev[i] = (lv != pv);
        else if (md == 0) ev[i] = !lv;
        else if (md == 1) ev[i] = lv;
        else if (md == 2) ev[i] = lv && !pv;
        else ev[i] = !lv && pv;
      end
      if (busWe) begin
        case (busAddr)
          8'h00: mData = busWdata;
          8'h04: mDir = busWdata;
          8'h0C: mCfgLo = busWdata;
          8'h10: mCfgHi = busWdata;
          8'h14: mMask = busWdata;
          8'h18: mStat = mStat & ~busWdata;
          8'h1C: mEdge = busWdata;
          8'h84: mData = mData | busWdata;
          8'h88: mData = mData & ~busWdata;
          8'h8C: mData = mData ^ busWdata;
          default: ;
        endcase
      end
      mStat = mStat | ev;
      mPrev = mS2; mS2 = mS1; mS1 = padIn;
    end
  end

  function automatic bit [31:0] expRead();
    case (busAddr)
      8'h00: return mData;
      8'h04: return mDir;
      8'h08: return mS2;
      8'h0C: return mCfgLo;
      8'h10: return mCfgHi;
      8'h14: return mMask;
      8'h18: return mStat;
      8'h1C: return mEdge;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit [31:0] pend;
    pend = mStat & mMask;
    chk("R2", "padOut", padOut, mData);
    chk("R2", "padOe", padOe, mDir);
    chk(curReq, "busRdata", busRdata, expRead());
    chk("R11", "irqLow", {31'd0, irqLow}, {31'd0, |pend[15:0]});
    chk("R11", "irqHigh", {31'd0, irqHigh}, {31'd0, |pend[31:16]});
    chk("R12", "irqPin", {24'd0, irqPin}, {24'd0, pend[7:0]});
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    tick();
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    busAddr = a;
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    padIn = 32'hFFFF_0000;
    @(negedge clk);
    rd(8'h00, 1); rd(8'h18, 1); rd(8'h0C, 1);
    busAddr = 8'h00;
    rst_n = 1'b1;
    tick();

    // R13: register map and unmapped offsets
    curReq = "R13";
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'hA5A5_1234);
    wr(8'h14, 32'h0F0F_0F0F);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h00, 1); rd(8'h04, 1); rd(8'h14, 1);
    rd(8'h40, 1); rd(8'h84, 1); rd(8'h88, 1); rd(8'h8C, 1); rd(8'h1C, 1);

    // R4: aliases
    curReq = "R4";
    wr(8'h84, 32'h0000_00F0); rd(8'h00, 1);
    wr(8'h88, 32'hA000_0004); rd(8'h00, 1);
    wr(8'h8C, 32'hFFFF_0000); rd(8'h00, 1);
    wr(8'h84, 32'h0);  wr(8'h88, 32'h0); wr(8'h8C, 32'h0); rd(8'h00, 1);

    // R3: synchroniser delay
    curReq = "R3";
    busAddr = 8'h08;
    padIn = 32'h1234_5678; tick(); tick(); tick();
    padIn = 32'hDEAD_BEEF; tick(); tick();
    padIn = 32'h0; tick(); tick(); tick();

    // R5, R6: level modes on both halves
    curReq = "R6";
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h5555_5555);
    wr(8'h10, 32'h0000_0000);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 3);
    padIn = 32'h0000_0081; rd(8'h18, 4);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 2);
    curReq = "R5";
    wr(8'h0C, 32'h0000_0004);
    wr(8'h10, 32'h5555_5554);
    padIn = 32'hFFFE_0002; rd(8'h18, 3);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 3);

    // R7: edge modes
    curReq = "R7";
    wr(8'h0C, 32'hAAAA_AAAA);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 3);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 1);
    padIn = 32'h0001_0001; rd(8'h18, 4);
    padIn = 32'h0000_0000; rd(8'h18, 4);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 2);

    // R8: edge-select override
    curReq = "R8";
    wr(8'h1C, 32'h0010_0020);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, 2);
    padIn = 32'h0010_0020; rd(8'h18, 4);
    wr(8'h18, 32'hFFFF_FFFF);
    padIn = 32'h0; rd(8'h18, 4);

    // R9: masked pins still latch status, zero writes keep it
    curReq = "R9";
    wr(8'h14, 32'h0);
    padIn = 32'h8000_0003; rd(8'h18, 4);
    wr(8'h18, 32'h0); rd(8'h18, 1);
    wr(8'h14, 32'h0000_00FF); rd(8'h18, 2);
    wr(8'h18, 32'h0000_0001); rd(8'h18, 1);

    // R10: clear collides with persisting level event
    curReq = "R10";
    wr(8'h1C, 32'h0);
    wr(8'h0C, 32'h0000_0040);
    padIn = 32'h0000_0008; rd(8'h18, 3);
    wr(8'h18, 32'h0000_0008); wr(8'h18, 32'h0000_0008); rd(8'h18, 1);
    padIn = 32'h0; rd(8'h18, 3);
    wr(8'h18, 32'h0000_0008); rd(8'h18, 2);

    // R11, R12: mixed random traffic
    curReq = "R11";
    wr(8'h14, 32'h00FF_00A5);
    for (int n = 0; n < 300; n++) begin
      padIn = $urandom;
      if (n % 7 == 0) wr(8'h18, $urandom);
      else if (n % 11 == 0) wr(8'h0C, $urandom);
      else if (n % 13 == 0) wr(8'h10, $urandom);
      else if (n % 17 == 0) wr(8'h1C, $urandom);
      else rd(8'h18, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule